// File: doc/BRIEF.md
# Blank Sync Pedestal Level Encoder

This block sits in a video output path, just ahead of a model of a triple digital-to-analog converter. Each clock it takes one 24-bit pixel (red, green and blue bytes), a blank input and a sync input. From these it produces, for each colour channel, the 8-bit code to convert and a set of flags. The flags tell the converter model which fixed current levels to add: a sync level on each true output, blank and sync levels on the complementary outputs, and a black pedestal.

An 8-bit configuration word selects the behaviour:
- which channels carry sync;
- whether the complementary outputs honour blank and sync;
- whether black sits at 0 IRE or at 7.5 IRE;
- whether the display is interlaced, a state the block hands on to the timing logic.

The block adopts a new configuration word only on the first cycle of a blanking interval. A change written in the middle of a line therefore leaves the active video alone. Every output is registered, and the latency is one clock, the same for all three channels.

Top module: `blank_sync_level_enc`

## Requirements
- R1: While rst_n is low, and on the first sample after rst_n rises, every output is zero. The active configuration also resets to zero.
- R2: When blank_i is low, code_o equals the pix_i value from one clock earlier. The layout is red in bits 23:16, green in bits 15:8 and blue in bits 7:0.
- R3: When blank_i was high one clock earlier, code_o is zero, ped_o is 0 and blank_o is 1.
- R4: When blank_i was low, ped_o equals bit 5 of the active configuration (0 means 0 IRE, 1 means 7.5 IRE).
- R5: sync_o[2] (red), sync_o[1] (green) and sync_o[0] (blue) each equal the previous sync_i ANDed with configuration bit 4, bit 3 and bit 2 respectively.
- R6: inv_blank_o equals the previous blank_i ANDed with configuration bit 0.
- R7: inv_sync_o equals the previous sync_i ANDed with configuration bit 1.
- R8: interlace_o equals bit 7 of the active configuration (1 means interlaced).
- R9: The active configuration is loaded from cfg_i only in a cycle where blank_i is high and was low in the cycle before; a cycle right after reset counts as "was low". In that cycle the newly loaded word already governs the outputs. At any other time cfg_i has no effect, and bit 6 never has any effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_i | input | 8 | Configuration word, adopted at the start of a blanking interval |
| pix_i | input | 24 | Pixel: red, green, blue bytes from high to low |
| blank_i | input | 1 | Blank, active high |
| sync_i | input | 1 | Sync, active high |
| code_o | output | 24 | Per-channel codes for the converters |
| blank_o | output | 1 | Blank flag for the true outputs |
| ped_o | output | 1 | Black pedestal flag |
| sync_o | output | 3 | Sync flags for red, green and blue |
| inv_blank_o | output | 1 | Blank flag for the complementary outputs |
| inv_sync_o | output | 1 | Sync flag for the complementary outputs |
| interlace_o | output | 1 | Interlaced display state for the timing logic |

## Verification
The assertions take for granted that every input is synchronous to the rising edge of clk and settled before it. The configuration-hold property also assumes that cfg_i is sampled at no edge other than the rising one. The bench changes all inputs on the falling edge and reads the outputs on the next falling edge, so each value seen at a rising edge is unambiguous.

The stimulus walks through all 256 configuration words. For each word it runs an active-video cycle, a blank start, a sync pulse inside the blank and a return to video. It also presents a different cfg_i outside every blank start, so that any leak of a mid-line configuration change shows up in the next comparison.

// File: rtl/blank_sync_level_enc.sv
module blank_sync_level_enc #(
  parameter int CW = 8,
  parameter int NCH = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [7:0]        cfg_i,
  input  logic [NCH*CW-1:0] pix_i,
  input  logic              blank_i,
  input  logic              sync_i,
  output logic [NCH*CW-1:0] code_o,
  output logic              blank_o,
  output logic              ped_o,
  output logic [NCH-1:0]    sync_o,
  output logic              inv_blank_o,
  output logic              inv_sync_o,
  output logic              interlace_o
);
  localparam int PW = NCH * CW;
  localparam int SYNC_EN_LSB = 2;

  logic       blank_q;
  logic [7:0] cfg_q;
  logic [7:0] cfg_use;
  logic       start;
  logic       unused_cfg;

  assign start      = blank_i & ~blank_q;
  assign cfg_use    = start ? cfg_i : cfg_q;
  assign unused_cfg = cfg_i[6] ^ cfg_q[6];
  assign interlace_o = cfg_q[7];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      blank_q     <= 1'b0;
      cfg_q       <= '0;
      blank_o     <= 1'b0;
      ped_o       <= 1'b0;
      inv_blank_o <= 1'b0;
      inv_sync_o  <= 1'b0;
    end else begin
      blank_q     <= blank_i;
      cfg_q       <= cfg_use;
      blank_o     <= blank_i;
      ped_o       <= ~blank_i & cfg_use[5];
      inv_blank_o <= blank_i & cfg_use[0];
      inv_sync_o  <= sync_i & cfg_use[1];
    end
  end

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        code_o[ch*CW +: CW] <= '0;
        sync_o[ch]          <= 1'b0;
      end else begin
        code_o[ch*CW +: CW] <= blank_i ? '0 : pix_i[ch*CW +: CW];
        sync_o[ch]          <= sync_i & cfg_use[SYNC_EN_LSB + ch];
      end
    end
  end

  // R2
  video_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !blank_o) |-> code_o == $past(pix_i));

  // R3
  blank_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    blank_o |-> (code_o == {PW{1'b0}} && !ped_o));

  // R5
  sync_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && |sync_o) |-> $past(sync_i));

  // R6
  inv_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inv_blank_o |-> blank_o);

  // R7
  inv_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && inv_sync_o) |-> $past(sync_i));

  // R9
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(blank_i && !blank_q) |=> $stable(interlace_o));
endmodule

// File: tb/tb_blank_sync_level_enc.sv
module tb_blank_sync_level_enc;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  cfg_i = '0;
  logic [23:0] pix_i = '0;
  logic        blank_i = 1'b0;
  logic        sync_i = 1'b0;
  logic [23:0] code_o;
  logic        blank_o, ped_o, inv_blank_o, inv_sync_o, interlace_o;
  logic [2:0]  sync_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [7:0] exp_cfg = '0;
  logic       prev_blank = 1'b0;

  always #2 clk = ~clk;

  blank_sync_level_enc dut (
    .clk(clk), .rst_n(rst_n), .cfg_i(cfg_i), .pix_i(pix_i),
    .blank_i(blank_i), .sync_i(sync_i), .code_o(code_o),
    .blank_o(blank_o), .ped_o(ped_o), .sync_o(sync_o),
    .inv_blank_o(inv_blank_o), .inv_sync_o(inv_sync_o),
    .interlace_o(interlace_o)
  );

  task automatic chk(input string tag, input logic [23:0] act, input logic [23:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step(input logic [23:0] pix, input logic b, input logic s, input logic [7:0] cfg);
    logic [23:0] ecode;
    @(negedge clk);
    pix_i = pix; blank_i = b; sync_i = s; cfg_i = cfg;
    if (b && !prev_blank) exp_cfg = cfg;
    prev_blank = b;
    ecode = b ? 24'h0 : pix;
    @(negedge clk);
    chk(b ? "R3 code" : "R2 code", code_o, ecode);
    chk("R3 blank_o", {23'h0, blank_o}, {23'h0, b});
    chk("R4 ped_o", {23'h0, ped_o}, {23'h0, ~b & exp_cfg[5]});
    chk("R5 sync_o", {21'h0, sync_o}, {21'h0, s & exp_cfg[4], s & exp_cfg[3], s & exp_cfg[2]});
    chk("R6 inv_blank_o", {23'h0, inv_blank_o}, {23'h0, b & exp_cfg[0]});
    chk("R7 inv_sync_o", {23'h0, inv_sync_o}, {23'h0, s & exp_cfg[1]});
    chk("R9/R8 interlace_o", {23'h0, interlace_o}, {23'h0, exp_cfg[7]});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    cfg_i = 8'hFF; pix_i = 24'hA5A5A5; sync_i = 1'b1;
    repeat (3) @(negedge clk);
    // R1: outputs held at zero during reset
    chk("R1 reset code", code_o, 24'h0);
    chk("R1 reset flags", {17'h0, blank_o, ped_o, sync_o, inv_blank_o, inv_sync_o, interlace_o}, 24'h0);
    cfg_i = 8'h00; pix_i = '0; sync_i = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after reset", {code_o[23:0]}, 24'h0);
    for (int c = 0; c < 256; c++) begin
      logic [7:0] k;
      k = c[7:0];
      step({k, k * 8'd3, 8'd255 - k}, 1'b0, 1'b0, ~k);
      step({k ^ 8'h5A, k, k + 8'd7}, 1'b1, 1'b0, k);
      step({k, k, k}, 1'b1, 1'b1, ~k);
      step({8'd255 - k, k ^ 8'hC3, k}, 1'b0, 1'b1, k ^ 8'h40);
      step({k + 8'd1, k + 8'd2, k + 8'd3}, 1'b0, 1'b0, ~k);
    end
    // R9: bit 6 never matters
    step(24'h123456, 1'b0, 1'b0, 8'h00);
    step(24'h000000, 1'b1, 1'b1, 8'h40);
    step(24'h654321, 1'b0, 1'b1, 8'hBF);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule